// File: doc/BRIEF.md
# Serial Port FIFO Buffering Front-End

This block sits between a host register bus and a serial communications controller. When it is switched off, every host access in the controller's address window reaches the controller unchanged. When it is switched on, host traffic on channel A's data port is served by two 64-byte FIFOs instead. Writes fill a transmit FIFO, which hands one byte to the controller each time the controller reports a free transmit buffer. Reads drain a receive FIFO, which the controller fills with the bytes it receives. Control-port accesses for both channels always reach the controller. This includes the indirect path to the controller's own transmit and receive buffers, which uses a pointer write to register 8 followed by a control-port data access. That path never touches the FIFOs.

A control register enables the FIFOs and holds a reset bit for each FIFO, a pattern-detect enable and a receive-timeout enable. A reset bit takes effect only while the FIFOs are disabled, so software clears a FIFO by disabling the FIFOs, setting the bit and then clearing it. A read-only status register reports the FIFO flags and the pending receive interrupt. The receive interrupt is raised when the receive FIFO is half full or more, or when the receive FIFO has held data for a programmable number of idle clocks. If the half-full flag reads clear while the interrupt is pending, the cause was the timeout.

Top module: `serial_fifo_front`

Host address map (3 bits): 0 = channel A data, 1 = channel A control, 2 = channel B data, 3 = channel B control, 4 = FIFO control, 5 = FIFO status, 6 = timeout limit, 7 = reads zero. Addresses 0 to 3 map onto controller address bits [1:0].

## Requirements
- R1: After reset the FIFOs are disabled, the control register reads 0x00, the status register reads 0x09 (both FIFOs empty) and rx_irq is low.
- R2: While enabled (control bit 0), host writes to address 0 enter the transmit FIFO and raise no scc_wr. Bytes leave in write order, one per clock in which scc_tx_ready is high, on scc_tx_byte qualified by scc_tx_valid.
- R3: While enabled, host reads of address 0 return receive-FIFO bytes in arrival order, with data on bus_rdata one clock after the read strobe. A read of an empty FIFO returns 0x00.
- R4: A FIFO holds at most 64 bytes. A write to a full FIFO is dropped, and the 64 stored bytes are kept.
- R5: While the FIFOs are disabled, control bit 1 clears the transmit FIFO and control bit 2 clears the receive FIFO. Each bit affects only its own FIFO.
- R6: While the FIFOs are enabled, the reset bits have no effect on FIFO contents.
- R7: The status register holds: bit 0 tx empty, bit 1 tx full, bit 2 tx half-full-or-more, bit 3 rx empty, bit 4 rx full, bit 5 rx half-full-or-more (32 or more), bit 6 receive interrupt pending, bit 7 zero.
- R8: rx_irq rises when the enabled receive FIFO holds 32 or more bytes. When this is the cause, status bit 5 reads 1.
- R9: With timeout enabled (control bit 4), rx_irq rises after the receive FIFO has been non-empty for the number of clocks in the limit register (address 6, reset value 32) with no received byte and no host data read. Status bit 5 then reads 0. A received byte or a host read restarts the count.
- R10: Accesses to addresses 1 and 3, including the register-8 indirect sequence, reach the controller (scc_wr / scc_rd with matching scc_addr) whether or not the FIFOs are enabled.
- R11: While the FIFOs are disabled, accesses to address 0 reach the controller, and read data comes from scc_rdata.
- R12: A host data read and a received byte in the same clock both take effect, and byte order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 3 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid one clock after bus_rd |
| rx_irq | output | 1 | Receive interrupt (half full or timeout) |
| scc_wr | output | 1 | Forwarded write strobe to controller |
| scc_rd | output | 1 | Forwarded read strobe to controller |
| scc_addr | output | 2 | Controller port select |
| scc_wdata | output | 8 | Forwarded write data |
| scc_rdata | input | 8 | Controller read data, same clock as scc_rd |
| scc_tx_ready | input | 1 | Controller transmit buffer can take a byte |
| scc_tx_valid | output | 1 | Transmit byte handed to controller |
| scc_tx_byte | output | 8 | Transmit byte |
| scc_rx_valid | input | 1 | Controller delivers a received byte |
| scc_rx_byte | input | 8 | Received byte |

## Verification
The receive FIFO can take a byte from the controller and give one to the host in the same clock. That clock also restarts the timeout count for two reasons at once. The bench loads three bytes, then raises a data-port read and scc_rx_valid together. It judges the result by the byte returned, by the order of the three bytes read afterwards and by the final empty status. A random mix of receive pushes and host reads against a queue model covers other chance overlaps. In the same way, a host write and a transmit drain can coincide.

// File: rtl/sfb_pkg.sv
`timescale 1ns/1ps
package sfb_pkg;
  localparam logic [2:0] ADR_DATA_A = 3'd0;
  localparam logic [2:0] ADR_CTRL_A = 3'd1;
  localparam logic [2:0] ADR_DATA_B = 3'd2;
  localparam logic [2:0] ADR_CTRL_B = 3'd3;
  localparam logic [2:0] ADR_FCTL   = 3'd4;
  localparam logic [2:0] ADR_FSTAT  = 3'd5;
  localparam logic [2:0] ADR_TLIM   = 3'd6;

  // bit 0 enable, bit 1 tx clear, bit 2 rx clear, bit 3 pattern, bit 4 timeout
  typedef struct packed {
    logic to_en;
    logic pat_en;
    logic rx_clr;
    logic tx_clr;
    logic en;
  } fctl_t;

  localparam int FCTL_W = $bits(fctl_t);
endpackage

// File: rtl/sfb_fifo.sv
`timescale 1ns/1ps
// Synchronous FIFO, DEPTH must be a power of two. Registered read port.
module sfb_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic          half
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp, cnt;
  logic          do_push, do_pop;

  assign cnt     = wp - rp;
  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign half    = (cnt >= (AW+1)'(DEPTH/2));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (do_pop) dout <= mem[rp[AW-1:0]];
    else if (pop)    dout <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
  p_full_keep_r4: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop && !clr |=> full);
  p_clr_empty_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
  p_pop_zero_r3: assert property (@(posedge clk) disable iff (rst)
    pop && empty && !clr |=> dout == '0);
endmodule

// File: rtl/sfb_rx_timer.sv
`timescale 1ns/1ps
// Idle counter: counts while armed, restarts on kick, saturates at limit.
module sfb_rx_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          kick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || kick || !arm) cnt <= '0;
    else if (cnt != limit)   cnt <= cnt + 1'b1;
  end

  assign expired = arm && (cnt == limit);

  p_kick_restart_r9: assert property (@(posedge clk) disable iff (rst)
    kick |=> cnt == '0);
endmodule

// File: rtl/serial_fifo_front.sv
`timescale 1ns/1ps
module serial_fifo_front
  import sfb_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DEPTH     = 64,
  parameter int TW        = 8,
  parameter int TLIM_INIT = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rx_irq,
  output logic          scc_wr,
  output logic          scc_rd,
  output logic [1:0]    scc_addr,
  output logic [DW-1:0] scc_wdata,
  input  logic [DW-1:0] scc_rdata,
  input  logic          scc_tx_ready,
  output logic          scc_tx_valid,
  output logic [DW-1:0] scc_tx_byte,
  input  logic          scc_rx_valid,
  input  logic [DW-1:0] scc_rx_byte
);
  fctl_t         ctl_q;
  logic [TW-1:0] tlim_q;
  logic          in_scc, redirect;
  logic          tx_push, tx_pop, rx_push, rx_pop;
  logic          tx_clr, rx_clr;
  logic          tx_empty, tx_full, tx_half;
  logic          rx_empty, rx_full, rx_half;
  logic [DW-1:0] rx_dout;
  logic          tmo;
  logic          rsel_q;
  logic [DW-1:0] rreg_q;
  logic [7:0]    stat;

  // routing
  assign in_scc    = (bus_addr[2] == 1'b0);
  assign redirect  = ctl_q.en && (bus_addr == ADR_DATA_A);
  assign scc_wr    = bus_wr && in_scc && !redirect;
  assign scc_rd    = bus_rd && in_scc && !redirect;
  assign scc_addr  = bus_addr[1:0];
  assign scc_wdata = bus_wdata;

  assign tx_push = bus_wr && redirect;
  assign rx_pop  = bus_rd && redirect;
  assign rx_push = ctl_q.en && scc_rx_valid;
  assign tx_pop  = ctl_q.en && scc_tx_ready && !tx_empty;
  assign tx_clr  = ctl_q.tx_clr && !ctl_q.en;
  assign rx_clr  = ctl_q.rx_clr && !ctl_q.en;

  sfb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(tx_push), .din(bus_wdata), .pop(tx_pop), .dout(scc_tx_byte),
    .empty(tx_empty), .full(tx_full), .half(tx_half));

  sfb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(rx_push), .din(scc_rx_byte), .pop(rx_pop), .dout(rx_dout),
    .empty(rx_empty), .full(rx_full), .half(rx_half));

  sfb_rx_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst),
    .arm(ctl_q.en && ctl_q.to_en && !rx_empty),
    .kick(rx_push || rx_pop),
    .limit(tlim_q), .expired(tmo));

  assign stat = {1'b0, rx_irq, rx_half, rx_full, rx_empty,
                 tx_half, tx_full, tx_empty};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q        <= '0;
      tlim_q       <= TW'(TLIM_INIT);
      rsel_q       <= 1'b0;
      rreg_q       <= '0;
      rx_irq       <= 1'b0;
      scc_tx_valid <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADR_FCTL) ctl_q  <= fctl_t'(bus_wdata[FCTL_W-1:0]);
      if (bus_wr && bus_addr == ADR_TLIM) tlim_q <= bus_wdata[TW-1:0];
      rx_irq       <= ctl_q.en && (rx_half || tmo);
      scc_tx_valid <= tx_pop;
      rsel_q       <= rx_pop;
      if (bus_rd) begin
        if (in_scc)                      rreg_q <= scc_rdata;
        else if (bus_addr == ADR_FCTL)   rreg_q <= DW'(ctl_q);
        else if (bus_addr == ADR_FSTAT)  rreg_q <= DW'(stat);
        else if (bus_addr == ADR_TLIM)   rreg_q <= DW'(tlim_q);
        else                             rreg_q <= '0;
      end
    end
  end

  assign bus_rdata = rsel_q ? rx_dout : rreg_q;

  p_ctrl_pass_r10: assert property (@(posedge clk) disable iff (rst)
    bus_wr && (bus_addr == ADR_CTRL_A || bus_addr == ADR_CTRL_B)
      |-> scc_wr && scc_addr == bus_addr[1:0]);
  p_redirect_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_q.en && bus_wr && bus_addr == ADR_DATA_A |-> !scc_wr);
  p_rst_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_q.en) && !$past(rx_empty) && !$past(rx_pop) |-> !rx_empty);
  p_irq_data_r8: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(!rx_empty));
  p_txv_en_r2: assert property (@(posedge clk) disable iff (rst)
    scc_tx_valid |-> $past(ctl_q.en));
endmodule

// File: tb/sim_serial_fifo_front.sv
`timescale 1ns/1ps
module sim_serial_fifo_front;
  logic       clk = 0, rst = 1;
  logic       bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       rx_irq, scc_wr, scc_rd, scc_tx_valid;
  logic [1:0] scc_addr;
  logic [7:0] scc_wdata, scc_rdata, scc_tx_byte;
  logic       scc_tx_ready = 0, scc_rx_valid = 0;
  logic [7:0] scc_rx_byte = 0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic       l_wr, l_rd;
  logic [1:0] l_addr;
  logic [7:0] l_wdata;
  logic [7:0] got_tx [0:127];
  int         n_tx = 0;
  logic [7:0] mq [0:63];
  int         mh, mc;

  always #2.5 clk = ~clk;

  assign scc_rdata = 8'hC0 | {6'd0, scc_addr};

  serial_fifo_front u0 (.*);

  always @(negedge clk) if (scc_tx_valid && n_tx < 128) begin
    got_tx[n_tx] = scc_tx_byte;
    n_tx++;
  end

  function automatic logic [7:0] exp_stat(int txc, int rxc, bit irq);
    return {1'b0, irq, rxc >= 32, rxc == 64, rxc == 0,
            txc >= 32, txc == 64, txc == 0};
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    #1 l_wr = scc_wr; l_addr = scc_addr; l_wdata = scc_wdata;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 l_rd = scc_rd;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rx(logic [7:0] b);
    @(negedge clk); scc_rx_valid = 1; scc_rx_byte = b;
    @(negedge clk); scc_rx_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] txm [0:63];
    int tc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq", {7'd0, rx_irq}, 8'h00);
    rd(3'd4, d); check("R1 ctrl", d, 8'h00);
    rd(3'd5, d); check("R1 status", d, 8'h09);

    // R11 disabled pass-through of data port
    wr(3'd0, 8'h5A);
    check("R11 wr fwd", {l_wr, 5'd0, l_addr}, 8'h80);
    check("R11 wdata", l_wdata, 8'h5A);
    rd(3'd0, d); check("R11 rd data", d, 8'hC0);

    // enable with timeout
    wr(3'd4, 8'h11);
    // R10 control ports, register-8 indirect sequence
    wr(3'd1, 8'h08); check("R10 ptr A", {l_wr, 5'd0, l_addr}, 8'h81);
    wr(3'd1, 8'h77); check("R10 buf A", l_wdata, 8'h77);
    wr(3'd3, 8'h08); check("R10 ptr B", {l_wr, 5'd0, l_addr}, 8'h83);
    rd(3'd3, d); check("R10 rd B", d, 8'hC3);
    check("R10 rd strobe", {7'd0, l_rd}, 8'h01);

    // R2/R4 transmit fill with random data, then drain
    tc = 0;
    for (int i = 0; i < 67; i++) begin
      d = 8'($urandom);
      wr(3'd0, d);
      if (i == 0) check("R2 no scc_wr", {7'd0, l_wr}, 8'h00);
      if (tc < 64) begin txm[tc] = d; tc++; end
    end
    rd(3'd5, d); check("R4 R7 tx full", d, exp_stat(64, 0, 0));
    n_tx = 0;
    @(negedge clk); scc_tx_ready = 1;
    idle(80);
    scc_tx_ready = 0;
    check("R2 drain count", 8'(n_tx), 8'd64);
    for (int i = 0; i < 64; i++) check("R2 tx order", got_tx[i], txm[i]);
    rd(3'd5, d); check("R7 tx empty", d, exp_stat(0, 0, 0));

    // R3 receive order and empty read
    rx(8'h11); rx(8'h22); rx(8'h33);
    rd(3'd0, d); check("R3 rx0", d, 8'h11);
    rd(3'd0, d); check("R3 rx1", d, 8'h22);
    rd(3'd0, d); check("R3 rx2", d, 8'h33);
    rd(3'd0, d); check("R3 empty zero", d, 8'h00);

    // R8 half-full interrupt
    for (int i = 0; i < 32; i++) rx(8'(i + 1));
    idle(2);
    check("R8 irq", {7'd0, rx_irq}, 8'h01);
    rd(3'd5, d); check("R8 status", d, exp_stat(0, 32, 1));
    for (int i = 0; i < 32; i++) begin
      rd(3'd0, d); check("R3 half drain", d, 8'(i + 1));
    end
    idle(2);
    check("R8 irq clear", {7'd0, rx_irq}, 8'h00);

    // R9 timeout interrupt and restart
    wr(3'd6, 8'd20);
    rx(8'hA1); rx(8'hA2);
    idle(10); check("R9 early", {7'd0, rx_irq}, 8'h00);
    idle(20); check("R9 fire", {7'd0, rx_irq}, 8'h01);
    rd(3'd5, d); check("R9 status cause", d, exp_stat(0, 2, 1));
    rd(3'd0, d); check("R9 rd", d, 8'hA1);
    idle(3); check("R9 restart", {7'd0, rx_irq}, 8'h00);
    idle(12); check("R9 still quiet", {7'd0, rx_irq}, 8'h00);
    idle(15); check("R9 refire", {7'd0, rx_irq}, 8'h01);
    rd(3'd0, d); check("R9 last", d, 8'hA2);
    idle(3); check("R9 empty quiet", {7'd0, rx_irq}, 8'h00);

    // R6 reset ignored while enabled, R5 per-FIFO clear while disabled
    wr(3'd4, 8'h01);
    wr(3'd0, 8'hE1);
    rx(8'hE2);
    wr(3'd4, 8'h07);
    rd(3'd5, d); check("R6 ignored", d, exp_stat(1, 1, 0));
    wr(3'd4, 8'h04);
    rd(3'd5, d); check("R5 rx only", d, exp_stat(1, 0, 0));
    wr(3'd4, 8'h02);
    rd(3'd5, d); check("R5 tx", d, exp_stat(0, 0, 0));
    wr(3'd4, 8'h01);

    // R12 same-clock receive and host read
    rx(8'hB0); rx(8'hB1); rx(8'hB2);
    @(negedge clk);
    bus_rd = 1; bus_addr = 3'd0; scc_rx_valid = 1; scc_rx_byte = 8'hB3;
    @(negedge clk);
    bus_rd = 0; scc_rx_valid = 0;
    check("R12 head", bus_rdata, 8'hB0);
    rd(3'd0, d); check("R12 b1", d, 8'hB1);
    rd(3'd0, d); check("R12 b2", d, 8'hB2);
    rd(3'd0, d); check("R12 b3", d, 8'hB3);
    rd(3'd5, d); check("R12 empty", d, exp_stat(0, 0, 0));

    // R3/R4 random receive traffic against a queue model
    mh = 0; mc = 0;
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 5 < 3) begin
        d = 8'($urandom);
        rx(d);
        if (mc < 64) begin mq[(mh + mc) % 64] = d; mc++; end
      end else begin
        rd(3'd0, d);
        if (mc == 0) check("R3 rand empty", d, 8'h00);
        else begin
          check("R3 rand data", d, mq[mh]);
          mh = (mh + 1) % 64; mc--;
        end
      end
    end
    rd(3'd5, d);
    check("R4 R7 rand status", d & 8'hBF, exp_stat(0, mc, 0) & 8'hBF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule